// File: doc/BRIEF.md
# Address-Space Tagged Translation Buffer with Maintenance Commands

This block holds two small fully associative translation buffers, one for data and one for instruction fetch, each with eight entries by default. Software-style maintenance commands fill and clean them. A command selects a buffer and an operation: set that buffer's current address-space number (ASN), write a page entry, write a tag, clear every entry, clear only the entries that are not global, or clear the one entry that matches an address under the current ASN. On the data side a page-entry write only stages the value, and the tag write that follows inserts it. On the instruction side the tag is written first, and the page-entry write performs the insert.

Each entry keeps a virtual page tag, a physical page number (PPN), 4-bit read and write enable masks, fault-on-read and fault-on-write flags, a global flag and a 7-bit ASN. Inserted entries always take the ASN that is current for their buffer. A combinational lookup port reports a hit and its PPN. A read-back port returns any slot packed into a 64-bit word.

Top module: `asn_tlb_maint`

## Requirements
- R1: After a synchronous active-low reset, every slot of both buffers is invalid. Every lookup misses, every read-back returns `rd_valid`=0 and `rd_data`=0, and `gh_err` is 0.
- R2: Data side: op 1 (page entry) only stages `cmd_data`, and no slot changes. A later op 2 (tag) inserts an entry made of the tag `cmd_data[42:13]`, the staged page entry and the data ASN.
- R3: Instruction side: op 2 (tag) only stores the tag `cmd_data[42:13]`, and no slot changes. A later op 1 inserts an entry made of `cmd_data` as the page entry, the stored tag and the instruction ASN. Op 0 sets a side's ASN from `cmd_data[6:0]`.
- R4: Every instruction-side entry has its write-enable mask at zero, whatever the page entry carried.
- R5: A lookup on `lk_side` hits when a valid entry's tag equals `lk_va[42:13]` and the entry is either global or holds that side's current ASN. On a hit, `lk_ppn` is the PPN of the lowest-numbered matching slot.
- R6: An insert that matches no entry fills slots in round-robin order starting at slot 0. The ninth such insert replaces slot 0.
- R7: An insert whose tag hits an existing entry under the current ASN (the R5 rule) overwrites that slot in place and does not move the round-robin pointer.
- R8: Op 3 invalidates every slot of the selected buffer.
- R9: Op 4 invalidates the non-global slots of the selected buffer and keeps the global ones.
- R10: Op 5 invalidates the slot that `cmd_data[42:13]` hits under the current ASN (the R5 rule) and leaves every other slot unchanged.
- R11: The page-entry input and the read-back word share one layout: fault-on-read bit 1, fault-on-write bit 2, global bit 4, read enables bits 11:8, write enables bits 15:12, PPN bits 56:32. Read-back adds the entry's ASN at bits 63:57. An invalid slot reads back as zero.
- R12: A page entry with a nonzero granularity-hint field (bits 6:5) reaching an insert causes no insert and leaves the pointer unchanged. It raises `gh_err[side]` for the one cycle after the command edge.
- R13: Commands to one side never change the other side. Opcodes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_side | input | 1 | 0 selects the data buffer, 1 the instruction buffer |
| cmd_op | input | 3 | 0 set ASN, 1 page entry, 2 tag, 3 clear all, 4 clear non-global, 5 clear one |
| cmd_data | input | 64 | Command operand |
| lk_side | input | 1 | Buffer searched by the lookup |
| lk_va | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 25 | PPN of the hit |
| rd_side | input | 1 | Buffer read back |
| rd_idx | input | 3 | Slot read back |
| rd_valid | output | 1 | Slot valid |
| rd_data | output | 64 | Packed slot contents |
| gh_err | output | 2 | Granularity-hint error pulse, one bit per side |

## Verification
A command acts on the clock edge that samples `cmd_valid`. Lookup and read-back are combinational from the slot registers, so they reflect the command from just after that edge. `gh_err` is registered: it is high in the cycle after the faulting command's edge and low again one edge later. The bench drives each command at a falling edge and checks the results at the next falling edge, one edge after the command. It checks `gh_err` clearing one further edge later, so every sample sits half a cycle away from the edge that produces it.

// File: rtl/tlbm_pkg.sv
// Shared widths, command codes, entry type and the packed read-back layout
// for the tagged translation buffer. Assumes PPN and ASN fields do not overlap.
package tlbm_pkg;
    parameter int TLB_VPN_W  = 30;
    parameter int TLB_PPN_W  = 25;
    parameter int TLB_ASN_W  = 7;
    parameter int TLB_PERM_W = 4;

    localparam int F_FONR = 1;
    localparam int F_FONW = 2;
    localparam int F_GBL  = 4;
    localparam int F_GH   = 5;
    localparam int GH_W   = 2;
    localparam int F_RE   = 8;
    localparam int F_WE   = 12;
    localparam int F_PPN  = 32;
    localparam int F_ASN  = 57;

    typedef enum logic [2:0] {
        OP_SET_ASN  = 3'd0,
        OP_PTE      = 3'd1,
        OP_TAG      = 3'd2,
        OP_INV_ALL  = 3'd3,
        OP_INV_PROC = 3'd4,
        OP_INV_ONE  = 3'd5
    } tlb_op_e;

    typedef struct packed {
        logic [TLB_VPN_W-1:0]  tag;
        logic [TLB_PPN_W-1:0]  ppn;
        logic [TLB_PERM_W-1:0] re;
        logic [TLB_PERM_W-1:0] we;
        logic                  fonr;
        logic                  fonw;
        logic                  gbl;
        logic [TLB_ASN_W-1:0]  asn;
    } tlb_entry_t;

    // Extract the page-entry fields of a 64-bit word (tag and ASN left zero).
    function automatic tlb_entry_t unpack_pte(input logic [63:0] v);
        tlb_entry_t e;
        e      = '0;
        e.fonr = v[F_FONR];
        e.fonw = v[F_FONW];
        e.gbl  = v[F_GBL];
        e.re   = v[F_RE +: TLB_PERM_W];
        e.we   = v[F_WE +: TLB_PERM_W];
        e.ppn  = v[F_PPN +: TLB_PPN_W];
        return e;
    endfunction

    // Build the packed read-back word of an entry.
    function automatic logic [63:0] pack_entry(input tlb_entry_t e);
        logic [63:0] v;
        v = '0;
        v[F_FONR] = e.fonr;
        v[F_FONW] = e.fonw;
        v[F_GBL]  = e.gbl;
        v[F_RE +: TLB_PERM_W] = e.re;
        v[F_WE +: TLB_PERM_W] = e.we;
        v[F_PPN +: TLB_PPN_W] = e.ppn;
        v[F_ASN +: TLB_ASN_W] = e.asn;
        return v;
    endfunction

    // Match rule: valid, same tag, and global or same address space.
    function automatic logic entry_hit(input logic vld, input tlb_entry_t e,
                                       input logic [TLB_VPN_W-1:0] tag,
                                       input logic [TLB_ASN_W-1:0] asn);
        return vld && (e.tag == tag) && (e.gbl || (e.asn == asn));
    endfunction
endpackage

// File: rtl/tlbm_cam.sv
// Entry storage and match logic of one buffer. Holds ENTRIES slots with a
// valid vector, two match ports (command probe, lookup) and one read port.
// Assumes the controller issues at most one of insert/invalidate per cycle.
module tlbm_cam
    import tlbm_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_entry_t           wr_entry,
    input  logic                 inv_all,
    input  logic                 inv_proc,
    input  logic                 inv_one,
    input  logic [TLB_VPN_W-1:0] probe_tag,
    input  logic [TLB_ASN_W-1:0] probe_asn,
    output logic [ENTRIES-1:0]   probe_hit,
    input  logic [TLB_VPN_W-1:0] lk_tag,
    input  logic [TLB_ASN_W-1:0] lk_asn,
    output logic                 lk_hit,
    output logic [TLB_PPN_W-1:0] lk_ppn,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_vld,
    output tlb_entry_t           rd_entry
);
    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] gbl_vec;
    logic [ENTRIES-1:0] lk_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign gbl_vec[g]   = ent_q[g].gbl;
        assign probe_hit[g] = entry_hit(vld_q[g], ent_q[g], probe_tag, probe_asn);
        assign lk_vec[g]    = entry_hit(vld_q[g], ent_q[g], lk_tag, lk_asn);
    end

    // Valid bits: reset, invalidations, then set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (inv_all)
                vld_q <= '0;
            else if (inv_proc)
                vld_q <= vld_q & gbl_vec;
            else if (inv_one)
                vld_q <= vld_q & ~probe_hit;
            else if (wr_en)
                vld_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: written on insert only; masked by valid elsewhere.
    always_ff @(posedge clk) begin
        if (wr_en)
            ent_q[wr_idx] <= wr_entry;
    end

    // Lookup result: PPN of the lowest-numbered hitting slot.
    always_comb begin
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (lk_vec[i]) lk_ppn = ent_q[i].ppn;
    end
    assign lk_hit = |lk_vec;

    // Read port.
    assign rd_vld   = vld_q[rd_idx];
    assign rd_entry = ent_q[rd_idx];

    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (vld_q == '0)); // R8
    AST_INV_PROC_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        inv_proc |=> (vld_q == $past(vld_q & gbl_vec))); // R9
    AST_INV_ONE_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one |=> ((vld_q & $past(probe_hit)) == '0)); // R10
endmodule

// File: rtl/tlbm_ctrl.sv
// Command sequencer of one buffer: ASN register, staging register, insert
// ordering (selected by IS_INSN), round-robin victim pointer and the
// granularity-hint error. Assumes cmd_go is already qualified by side.
module tlbm_ctrl
    import tlbm_pkg::*;
#(
    parameter bit IS_INSN  = 1'b0,
    parameter int ENTRIES  = 8,
    parameter int PG_SHIFT = 13,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_go,
    input  logic [2:0]           cmd_op,
    input  logic [63:0]          cmd_data,
    input  logic [ENTRIES-1:0]   probe_hit,
    output logic [TLB_VPN_W-1:0] probe_tag,
    output logic [TLB_ASN_W-1:0] cur_asn,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output tlb_entry_t           wr_entry,
    output logic                 inv_all,
    output logic                 inv_proc,
    output logic                 inv_one,
    output logic                 gh_err
);
    logic [63:0]          stage_q;
    logic [IDX_W-1:0]     rr_q;
    logic [TLB_ASN_W-1:0] asn_q;
    logic                 err_q;

    logic                 op_asn, op_pte, op_tag;
    logic                 stage_we, ins_go, gh_bad, hit_any;
    logic [63:0]          ins_raw;
    logic [TLB_VPN_W-1:0] ins_tag, cmd_tag;
    logic [IDX_W-1:0]     hit_idx;

    assign op_asn   = cmd_go && (cmd_op == OP_SET_ASN);
    assign op_pte   = cmd_go && (cmd_op == OP_PTE);
    assign op_tag   = cmd_go && (cmd_op == OP_TAG);
    assign inv_all  = cmd_go && (cmd_op == OP_INV_ALL);
    assign inv_proc = cmd_go && (cmd_op == OP_INV_PROC);
    assign inv_one  = cmd_go && (cmd_op == OP_INV_ONE);
    assign cmd_tag  = cmd_data[PG_SHIFT +: TLB_VPN_W];

    if (IS_INSN) begin : g_insn
        assign stage_we = op_tag;
        assign ins_go   = op_pte;
        assign ins_raw  = cmd_data;
        assign ins_tag  = stage_q[PG_SHIFT +: TLB_VPN_W];
    end else begin : g_data
        assign stage_we = op_pte;
        assign ins_go   = op_tag;
        assign ins_raw  = stage_q;
        assign ins_tag  = cmd_tag;
    end

    assign gh_bad    = ins_go && (ins_raw[F_GH +: GH_W] != '0);
    assign wr_en     = ins_go && !gh_bad;
    assign probe_tag = ins_go ? ins_tag : cmd_tag;
    assign cur_asn   = asn_q;
    assign hit_any   = |probe_hit;
    assign gh_err    = err_q;

    // Lowest-numbered slot hit by the probe.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (probe_hit[i]) hit_idx = IDX_W'(i);
    end

    // Victim choice and the entry to write.
    always_comb begin
        wr_idx   = hit_any ? hit_idx : rr_q;
        wr_entry = unpack_pte(ins_raw);
        wr_entry.tag = ins_tag;
        wr_entry.asn = asn_q;
        if (IS_INSN) wr_entry.we = '0;
    end

    // Sequencer state: ASN, staging, round-robin pointer, error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            rr_q    <= '0;
            asn_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= gh_bad;
            if (op_asn)   asn_q   <= cmd_data[TLB_ASN_W-1:0];
            if (stage_we) stage_q <= cmd_data;
            if (wr_en && !hit_any)
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    AST_GH_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        gh_bad |=> (rr_q == $past(rr_q))); // R12
    AST_INPLACE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_any) |=> (rr_q == $past(rr_q))); // R7
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !gh_bad) |=> !err_q); // R12
endmodule

// File: rtl/asn_tlb_maint.sv
// Top: a data buffer and an instruction buffer, each a sequencer plus slot
// storage, sharing one command port, one lookup port and one read-back port.
// Assumes at most one command per cycle.
module asn_tlb_maint
    import tlbm_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int PG_SHIFT = 13,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_side,
    input  logic [2:0]           cmd_op,
    input  logic [63:0]          cmd_data,
    input  logic                 lk_side,
    input  logic [63:0]          lk_va,
    output logic                 lk_hit,
    output logic [TLB_PPN_W-1:0] lk_ppn,
    input  logic                 rd_side,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [63:0]          rd_data,
    output logic [1:0]           gh_err
);
    logic [1:0]           s_lk_hit;
    logic [1:0]           s_rd_vld;
    logic [TLB_PPN_W-1:0] s_lk_ppn [2];
    tlb_entry_t           s_rd_ent [2];
    logic [TLB_VPN_W-1:0] lk_tag;

    assign lk_tag = lk_va[PG_SHIFT +: TLB_VPN_W];

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic                 go, wr_en, inv_all, inv_proc, inv_one;
        logic [ENTRIES-1:0]   probe_hit;
        logic [TLB_VPN_W-1:0] probe_tag;
        logic [TLB_ASN_W-1:0] cur_asn;
        logic [IDX_W-1:0]     wr_idx;
        tlb_entry_t           wr_entry;

        assign go = cmd_valid && (cmd_side == 1'(s));

        tlbm_ctrl #(
            .IS_INSN (s == 1),
            .ENTRIES (ENTRIES),
            .PG_SHIFT(PG_SHIFT)
        ) ctrl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_go   (go),
            .cmd_op   (cmd_op),
            .cmd_data (cmd_data),
            .probe_hit(probe_hit),
            .probe_tag(probe_tag),
            .cur_asn  (cur_asn),
            .wr_en    (wr_en),
            .wr_idx   (wr_idx),
            .wr_entry (wr_entry),
            .inv_all  (inv_all),
            .inv_proc (inv_proc),
            .inv_one  (inv_one),
            .gh_err   (gh_err[s])
        );

        tlbm_cam #(
            .ENTRIES(ENTRIES)
        ) cam_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_idx   (wr_idx),
            .wr_entry (wr_entry),
            .inv_all  (inv_all),
            .inv_proc (inv_proc),
            .inv_one  (inv_one),
            .probe_tag(probe_tag),
            .probe_asn(cur_asn),
            .probe_hit(probe_hit),
            .lk_tag   (lk_tag),
            .lk_asn   (cur_asn),
            .lk_hit   (s_lk_hit[s]),
            .lk_ppn   (s_lk_ppn[s]),
            .rd_idx   (rd_idx),
            .rd_vld   (s_rd_vld[s]),
            .rd_entry (s_rd_ent[s])
        );
    end

    // Output selection by side; invalid slots read back as zero.
    always_comb begin
        lk_hit   = s_lk_hit[lk_side];
        lk_ppn   = s_lk_ppn[lk_side];
        rd_valid = s_rd_vld[rd_side];
        rd_data  = rd_valid ? pack_entry(s_rd_ent[rd_side]) : '0;
    end

    AST_INSN_NO_WRITE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_side && rd_valid) |-> (rd_data[F_WE +: TLB_PERM_W] == '0)); // R4
    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R11
endmodule

// File: tb/asn_tlb_maint_tb.sv
`timescale 1ns/1ps
module asn_tlb_maint_tb_top;
    import tlbm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_side = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_data = '0;
    logic        lk_side = 1'b0;
    logic [63:0] lk_va = '0;
    logic        lk_hit;
    logic [24:0] lk_ppn;
    logic        rd_side = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [1:0]  gh_err;

    int nchk = 0, nfail = 0;
    logic [63:0] m_word [2][8];
    bit          m_vld  [2][8];

    always #4 clk = ~clk;

    asn_tlb_maint dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_side(cmd_side),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .lk_side(lk_side), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rd_side(rd_side), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .gh_err(gh_err)
    );

    function automatic logic [63:0] mk(int ppn, int re, int we, int fr, int fw,
                                       int gbl, int gh, int asn);
        logic [63:0] v = '0;
        v[1] = fr[0]; v[2] = fw[0]; v[4] = gbl[0]; v[6:5] = gh[1:0];
        v[11:8] = re[3:0]; v[15:12] = we[3:0];
        v[56:32] = ppn[24:0]; v[63:57] = asn[6:0];
        return v;
    endfunction

    function automatic logic [63:0] va(int tag);
        return 64'(tag) << 13;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic side, input logic [2:0] op, input logic [63:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_side = side; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_slots(input logic side, input string req);
        for (int i = 0; i < 8; i++) begin
            rd_side = side; rd_idx = 3'(i); #1;
            chk(req, 64'(rd_valid), 64'(m_vld[side][i]));
            chk(req, rd_data, m_vld[side][i] ? m_word[side][i] : 64'd0);
        end
    endtask

    task automatic look(input logic side, input int tag, input bit hit,
                        input int ppn, input string req);
        lk_side = side; lk_va = va(tag); #1;
        chk(req, 64'(lk_hit), 64'(hit));
        if (hit) chk(req, 64'(lk_ppn), 64'(ppn[24:0]));
    endtask

    task automatic set_slot(input logic side, input int i, input logic [63:0] w);
        m_vld[side][i] = 1'b1; m_word[side][i] = w;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin m_vld[s][i] = 0; m_word[s][i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_slots(0, "R1"); check_slots(1, "R1");
        look(0, 'h100, 0, 0, "R1"); look(1, 'h100, 0, 0, "R1");
        chk("R1", 64'(gh_err), 64'd0);

        // R2: data staging then insert with ASN 5
        do_cmd(0, OP_SET_ASN, 64'd5);
        do_cmd(0, OP_PTE, mk('h1000, 0, 'hF, 0, 0, 0, 0, 0));
        check_slots(0, "R2"); look(0, 'h100, 0, 0, "R2");
        for (int i = 0; i < 8; i++) begin
            if (i != 0) do_cmd(0, OP_PTE, mk('h1000 + i, i, 15 - i, i & 1, (i >> 1) & 1, i == 3, 0, 0));
            do_cmd(0, OP_TAG, va('h100 + i));
            set_slot(0, i, mk('h1000 + i, i, 15 - i, i & 1, (i >> 1) & 1, i == 3, 0, 5));
        end
        check_slots(0, "R11"); // R6 fill order plus R11 layout
        // R5: lookup sweep over two ASNs
        for (int a = 5; a < 7; a++) begin
            do_cmd(0, OP_SET_ASN, 64'(a));
            for (int i = 0; i < 8; i++) look(0, 'h100 + i, (a == 5) || (i == 3), 'h1000 + i, "R5");
            look(0, 'h1FF, 0, 0, "R5");
        end
        do_cmd(0, OP_SET_ASN, 64'd5);
        // R6: ninth new insert wraps to slot 0
        do_cmd(0, OP_PTE, mk('h2000, 1, 1, 0, 0, 0, 0, 0));
        do_cmd(0, OP_TAG, va('h200));
        set_slot(0, 0, mk('h2000, 1, 1, 0, 0, 0, 0, 5));
        check_slots(0, "R6"); look(0, 'h100, 0, 0, "R6"); look(0, 'h200, 1, 'h2000, "R6");
        // R7: matching insert overwrites slot 2, pointer stays at 1
        do_cmd(0, OP_PTE, mk('h2222, 2, 2, 1, 1, 0, 0, 0));
        do_cmd(0, OP_TAG, va('h102));
        set_slot(0, 2, mk('h2222, 2, 2, 1, 1, 0, 0, 5));
        do_cmd(0, OP_PTE, mk('h2001, 3, 3, 0, 0, 0, 0, 0));
        do_cmd(0, OP_TAG, va('h201));
        set_slot(0, 1, mk('h2001, 3, 3, 0, 0, 0, 0, 5));
        check_slots(0, "R7");
        // R12: nonzero granularity hint, no insert, pointer held at 2
        do_cmd(0, OP_PTE, mk('h2002, 1, 1, 0, 0, 0, 1, 0));
        do_cmd(0, OP_TAG, va('h202));
        chk("R12", 64'(gh_err), 64'b01);
        @(negedge clk);
        chk("R12", 64'(gh_err), 64'b00);
        check_slots(0, "R12"); look(0, 'h202, 0, 0, "R12");
        do_cmd(0, OP_PTE, mk('h2003, 4, 4, 0, 0, 0, 0, 0));
        do_cmd(0, OP_TAG, va('h203));
        set_slot(0, 2, mk('h2003, 4, 4, 0, 0, 0, 0, 5));
        check_slots(0, "R12");
        // R10: single invalidate under ASN 6
        do_cmd(0, OP_SET_ASN, 64'd6);
        do_cmd(0, OP_INV_ONE, va('h103));
        m_vld[0][3] = 0;
        do_cmd(0, OP_INV_ONE, va('h104));
        check_slots(0, "R10");
        // R9: keep only global entries
        do_cmd(0, OP_SET_ASN, 64'd5);
        do_cmd(0, OP_PTE, mk('h3000, 5, 5, 0, 0, 1, 0, 0));
        do_cmd(0, OP_TAG, va('h300));
        set_slot(0, 3, mk('h3000, 5, 5, 0, 0, 1, 0, 5));
        do_cmd(0, OP_INV_PROC, 64'd0);
        for (int i = 0; i < 8; i++) if (i != 3) m_vld[0][i] = 0;
        check_slots(0, "R9");
        do_cmd(0, OP_SET_ASN, 64'd7);
        look(0, 'h300, 1, 'h3000, "R9");

        // R3/R4: instruction side ordering and write-enable clearing
        do_cmd(1, OP_SET_ASN, 64'd9);
        do_cmd(1, OP_TAG, va('h500));
        check_slots(1, "R3"); look(1, 'h500, 0, 0, "R3");
        do_cmd(1, OP_PTE, mk('h777, 'hA, 'hF, 1, 0, 0, 0, 0));
        set_slot(1, 0, mk('h777, 'hA, 0, 1, 0, 0, 0, 9));
        check_slots(1, "R4"); look(1, 'h500, 1, 'h777, "R3");
        do_cmd(1, OP_PTE, mk('h778, 'h3, 'h5, 0, 1, 0, 0, 0));
        set_slot(1, 0, mk('h778, 'h3, 0, 0, 1, 0, 0, 9));
        check_slots(1, "R7");
        do_cmd(1, OP_PTE, mk('h779, 1, 1, 0, 0, 0, 2, 0));
        chk("R12", 64'(gh_err), 64'b10);
        check_slots(1, "R12");
        // R13: sides independent, reserved ops ignored
        check_slots(0, "R13");
        do_cmd(0, OP_INV_ALL, 64'd0);
        for (int i = 0; i < 8; i++) m_vld[0][i] = 0;
        check_slots(0, "R8"); look(0, 'h300, 0, 0, "R8");
        check_slots(1, "R13");
        do_cmd(1, 3'd6, mk('h1, 1, 1, 0, 0, 0, 0, 0));
        do_cmd(1, 3'd7, va('h500));
        check_slots(1, "R13"); look(1, 'h500, 1, 'h778, "R13");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule